// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block monitors a parameterised set of request lines. Lines 0 to 15 carry general external inputs, and the higher lines carry internal sources such as supply monitoring, alarms or wake-up sources. Each line is first synchronised to the block clock. The block then looks for a low-to-high or a high-to-low transition, or both, as selected for that line. A detected edge sets a per-line pending flag, and that flag stays set until it is cleared.

Software can also set a pending flag through a trigger register. The pending flags feed two outputs, and each output has its own per-line mask. The interrupt output is a level: the OR over all lines of pending AND interrupt mask. The event output is a one-cycle pulse for each trigger whose line is enabled in the event mask.

Six 32-bit registers are reached through a simple word-addressed register bus. Bit n of each register belongs to line n. Bits above the implemented line count read as zero.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After synchronous reset, all six registers read 0 and both `irq_o` and `evt_o` are low.
- R2: Registers sit at byte offsets 0x00 (interrupt mask), 0x04 (event mask), 0x08 (rising select), 0x0C (falling select), 0x10 (software trigger) and 0x14 (pending). Bits at and above NUM_LINES read 0, so with 23 lines, writing 0xFFFFFFFF to a mask reads back 0x007FFFFF. Read data appears on `bus_rdata` one cycle after the read request.
- R3: `irq_o` is the registered OR over all lines of (pending AND interrupt mask). It updates one cycle after the pending flags change, and it stays low for lines whose mask bit is 0.
- R4: `evt_o` is high for exactly one cycle after each cycle in which a trigger occurs on a line whose event-mask bit is 1. This is independent of the interrupt mask.
- R5: With rising select bit n set, a 0-to-1 change on `lines_i[n]` sets pending bit n. The new flag is visible three clock edges after the input changes: two synchroniser stages and then the latch. The event pulse appears on that same edge.
- R6: With falling select bit n set, a 1-to-0 change sets pending bit n. With both select bits set, either edge sets it.
- R7: Writing 1 to software-trigger bit n sets pending bit n on that write edge, exactly as a hardware edge would. Trigger bit n then reads 1 until pending bit n is cleared, and clearing the pending bit also clears the trigger bit.
- R8: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R9: If a trigger on line n lands in the same cycle as a clear of pending bit n, the trigger wins and the bit stays 1.
- R10: An edge on a line whose select bit for that direction is 0 leaves pending and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_i | input | NUM_LINES | Asynchronous request lines |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Combined masked interrupt level |
| evt_o | output | 1 | Combined masked event pulse |

## Verification
The assertions assume the bus never writes the software-trigger and pending registers in the same cycle. This is always true, because a single address selects one register per access. They also assume that `lines_i` is held low while reset is asserted, so the synchroniser does not see a spurious edge after reset. The stimulus changes `lines_i` only on falling clock edges and issues one bus access at a time. It waits at least four cycles between line changes, so each edge can be attributed to a single trigger.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DATA_W = 32;

  // Register selected by byte offset bits [4:2]
  typedef enum logic [2:0] {
    SEL_IMASK = 3'd0,
    SEL_EMASK = 3'd1,
    SEL_RISE  = 3'd2,
    SEL_FALL  = 3'd3,
    SEL_SWT   = 3'd4,
    SEL_PEND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int NUM_LINES   = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= lines_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
  parameter int NUM_LINES = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] trig_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] sw_set_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] sw_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      sw_o   <= '0;
    end else begin
      pend_o <= (pend_o & ~clr_i) | trig_i;
      sw_o   <= (sw_o | sw_set_i) & ~clr_i;
    end
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~trig_i) != '0) |=> ((pend_o & $past(clr_i & ~trig_i)) == '0)); // R8

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (trig_i != '0) |=> ((pend_o & $past(trig_i)) == $past(trig_i))); // R9

  AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((sw_o & clr_i) != '0) |=> ((sw_o & $past(clr_i)) == '0)); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((pend_o & ~clr_i) != '0) |=> ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i))); // R8
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES   = 23,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_o,
  output logic                 evt_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]     word;
  logic                 wr;
  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] imask_q, emask_q, rise_en_q, fall_en_q;
  logic [NUM_LINES-1:0] rise, fall, trig, clr, sw_set, pend, sw_bits;

  assign word  = bus_addr[ADDR_W-1:2];
  assign wr    = bus_req & bus_we;
  assign wbits = bus_wdata[NUM_LINES-1:0];

  eic_sync_edge #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .lines_i(lines_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sw_set = (wr && word == SEL_W'(SEL_SWT))  ? wbits : '0;
  assign clr    = (wr && word == SEL_W'(SEL_PEND)) ? wbits : '0;
  assign trig   = (rise & rise_en_q) | (fall & fall_en_q) | sw_set;

  eic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig),
    .clr_i   (clr),
    .sw_set_i(sw_set),
    .pend_o  (pend),
    .sw_o    (sw_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      imask_q   <= '0;
      emask_q   <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (wr) begin
      if (word == SEL_W'(SEL_IMASK)) imask_q   <= wbits;
      if (word == SEL_W'(SEL_EMASK)) emask_q   <= wbits;
      if (word == SEL_W'(SEL_RISE))  rise_en_q <= wbits;
      if (word == SEL_W'(SEL_FALL))  fall_en_q <= wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      irq_o <= |(pend & imask_q);
      evt_o <= |(trig & emask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_req && !bus_we) begin
      case (word)
        SEL_W'(SEL_IMASK): bus_rdata <= DATA_W'(imask_q);
        SEL_W'(SEL_EMASK): bus_rdata <= DATA_W'(emask_q);
        SEL_W'(SEL_RISE):  bus_rdata <= DATA_W'(rise_en_q);
        SEL_W'(SEL_FALL):  bus_rdata <= DATA_W'(fall_en_q);
        SEL_W'(SEL_SWT):   bus_rdata <= DATA_W'(sw_bits);
        SEL_W'(SEL_PEND):  bus_rdata <= DATA_W'(pend);
        default:           bus_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ($past(imask_q) == '0) |-> !irq_o); // R3

  AST_EVT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ($past(emask_q) == '0) |-> !evt_o); // R4

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((pend & imask_q) != '0) |=> irq_o); // R3
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 23;
  localparam logic [4:0] A_IMASK = 5'h00, A_EMASK = 5'h04, A_RISE = 5'h08,
                         A_FALL = 5'h0C, A_SWT = 5'h10, A_PEND = 5'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] lines = '0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, evt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic rd_issued_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) uut (
    .clk(clk), .rst(rst), .lines_i(lines),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq), .evt_o(evt)
  );

  always @(posedge clk) rd_issued_q <= !rst && bus_req && !bus_we;

  // Monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_issued_q) begin
      item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read, actual %h expected none", "R2", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_neg(3);
    rst = 1'b0;
    wait_neg(1);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 evt", {31'd0, evt}, 32'd0);
    bus_read(A_IMASK, 32'h0, "R1 imask");
    bus_read(A_EMASK, 32'h0, "R1 emask");
    bus_read(A_RISE,  32'h0, "R1 rise");
    bus_read(A_FALL,  32'h0, "R1 fall");
    bus_read(A_SWT,   32'h0, "R1 swt");
    bus_read(A_PEND,  32'h0, "R1 pend");

    // R2 upper bits read zero, offsets
    bus_write(A_IMASK, 32'hFFFF_FFFF);
    bus_read(A_IMASK, 32'h007F_FFFF, "R2 imask width");
    bus_write(A_IMASK, 32'h0000_0001);
    bus_write(A_EMASK, 32'h0000_0002);
    bus_write(A_RISE,  32'h0000_0001);
    bus_write(A_FALL,  32'h0000_0002);
    bus_read(A_FALL, 32'h0000_0002, "R2 fall offset");
    bus_read(A_EMASK, 32'h0000_0002, "R2 emask offset");

    // R5 rising edge on line 0 (event masked for line 0)
    lines = 23'h1;
    wait_neg(3);
    chk("R4 evt masked line0", {31'd0, evt}, 32'd0);
    chk("R3 irq lags pending", {31'd0, irq}, 32'd0);
    wait_neg(1);
    chk("R3 irq on", {31'd0, irq}, 32'd1);
    bus_read(A_PEND, 32'h1, "R5 rise pend");

    // R10 rise on line 1 without rising select
    lines = 23'h3;
    wait_neg(4);
    chk("R10 evt quiet", {31'd0, evt}, 32'd0);
    bus_read(A_PEND, 32'h1, "R10 no pend");

    // R6 falling edge on line 1, event enabled
    lines = 23'h1;
    wait_neg(3);
    chk("R4 evt pulse", {31'd0, evt}, 32'd1);
    wait_neg(1);
    chk("R4 evt one cycle", {31'd0, evt}, 32'd0);
    bus_read(A_PEND, 32'h3, "R6 fall pend");

    // R8 clear semantics
    bus_write(A_PEND, 32'h0);
    bus_read(A_PEND, 32'h3, "R8 write0 no effect");
    bus_write(A_PEND, 32'h1);
    chk("R3 irq still high", {31'd0, irq}, 32'd1);
    wait_neg(1);
    chk("R3 irq drops", {31'd0, irq}, 32'd0);
    bus_read(A_PEND, 32'h2, "R8 write1 clears");
    bus_write(A_PEND, 32'h2);
    bus_read(A_PEND, 32'h0, "R8 all clear");

    // R7 software trigger
    bus_write(A_IMASK, 32'h0);
    bus_write(A_EMASK, 32'h10);
    bus_write(A_SWT, 32'h10);
    chk("R7 sw evt", {31'd0, evt}, 32'd1);
    bus_read(A_SWT, 32'h10, "R7 swt held");
    bus_read(A_PEND, 32'h10, "R7 sw pend");
    chk("R3 irq masked", {31'd0, irq}, 32'd0);
    bus_write(A_PEND, 32'h10);
    bus_read(A_SWT, 32'h0, "R7 swt self clear");
    bus_read(A_PEND, 32'h0, "R7 pend cleared");

    // R6 both edges on line 7
    bus_write(A_RISE, 32'h81);
    bus_write(A_FALL, 32'h82);
    lines = 23'h81;
    wait_neg(4);
    bus_read(A_PEND, 32'h80, "R6 both rise");
    bus_write(A_PEND, 32'h80);
    lines = 23'h01;
    wait_neg(4);
    bus_read(A_PEND, 32'h80, "R6 both fall");

    // R9 edge and clear in the same cycle
    lines = 23'h81;
    wait_neg(2);
    bus_write(A_PEND, 32'h80);
    bus_read(A_PEND, 32'h80, "R9 edge wins");
    bus_write(A_PEND, 32'h80);
    bus_read(A_PEND, 32'h0, "R8 final clear");

    wait_neg(2);
    chk("R2 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule